// File: doc/BRIEF.md
# Branch Resolution Flush Controller

This block holds the control-hazard logic of a five-stage in-order pipeline whose fetch unit always assumes that a branch falls through. The execute stage presents the resolved branch: a valid flag, the condition result and the target. When a branch turns out taken, the controller does four things in the same cycle:

- it steers the program counter to the target;
- it raises flush enables for the fetch/decode and decode/execute registers;
- it overrides any data-hazard stall request;
- it records the two fetch slots that were lost.

The controller owns the valid bit of the fetch/decode register and the control fields of the decode/execute register. It sanitises the decoded control bundle on its way into execute. A squashed or empty slot is not removed from the pipeline. It becomes a bubble whose valid, register-write and memory-write bits and ALU operation code are all zero. The bubble then moves through the later stages in lock step with its neighbours and changes nothing.

A branch that resolves not taken costs no cycle. A taken branch from execute (the third stage) costs exactly two slots. A saturating counter exposes the running total of lost slots.

Top module: `branch_flush_ctrl`

## Requirements
- R1: While `rst_n` is low at a rising edge, the next cycle shows `if_vld`, `ex_vld`, `ex_reg_wr`, `ex_mem_wr`, `ex_alu_op` and `penalty_cnt` all at zero.
- R2: In any cycle where `ex_br_vld` and `ex_br_taken` are both 1, `pc_sel` is 1 (1 = take target, 0 = sequential) and `pc_target` equals `ex_br_target` in that cycle. Otherwise `pc_sel` is 0.
- R3: `flush_ifid` and `flush_idex` are both 1 in exactly the cycles where a taken branch is presented, and both 0 in all other cycles.
- R4: In the cycle after a taken branch, `if_vld` is 0 and the execute bundle is a bubble: `ex_vld`, `ex_reg_wr` and `ex_mem_wr` are 0 and `ex_alu_op` is 0.
- R5: A branch that is not taken, or a set `ex_br_taken` while `ex_br_vld` is 0, leaves `penalty_cnt` unchanged, raises no flush and lets the decoded bundle pass.
- R6: When a taken branch and `stall_req` occur in the same cycle, `stall_out` is 0 and the flush result of R4 applies. Otherwise `stall_out` follows `stall_req`.
- R7: In the cycle after `stall_out` is 1, `if_vld` keeps its previous value and the execute bundle is a bubble.
- R8: With no flush and no stall, at each edge `if_vld` takes `fetch_vld`. The execute bundle takes `id_reg_wr`, `id_mem_wr` and `id_alu_op` with `ex_vld` = 1 when both the previous `if_vld` and `id_vld` were 1. Otherwise the bundle is all zero.
- R9: Each taken branch adds 2 to `penalty_cnt` at the next edge. The count saturates at all ones: it never wraps.
- R10: After a taken branch, with valid fetches continuing, the execute bundle holds bubbles in the two following cycles. A real instruction reaches it in the third.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| fetch_vld | input | 1 | Instruction arriving from fetch this cycle is valid |
| id_vld | input | 1 | Decoder marks the instruction in decode as real |
| id_reg_wr | input | 1 | Decoded register-write enable |
| id_mem_wr | input | 1 | Decoded memory-write enable |
| id_alu_op | input | ALUOP_W | Decoded ALU operation code |
| stall_req | input | 1 | Data-hazard stall request |
| ex_br_vld | input | 1 | Execute stage holds a branch |
| ex_br_taken | input | 1 | Resolved branch condition |
| ex_br_target | input | PC_W | Resolved branch target |
| pc_sel | output | 1 | Next-PC select, 1 = target |
| pc_target | output | PC_W | Redirect address |
| flush_ifid | output | 1 | Squash fetch/decode register |
| flush_idex | output | 1 | Squash decode/execute register |
| stall_out | output | 1 | Stall after flush priority |
| if_vld | output | 1 | Valid bit of fetch/decode register |
| ex_vld | output | 1 | Sanitised valid into execute |
| ex_reg_wr | output | 1 | Sanitised register-write enable |
| ex_mem_wr | output | 1 | Sanitised memory-write enable |
| ex_alu_op | output | ALUOP_W | Sanitised ALU operation code |
| penalty_cnt | output | CNT_W | Total lost slots, saturating |

## Verification
The redirect, both flush enables and the effective stall are combinational, so they are due in the same cycle as the branch or stall inputs that cause them. The fetch/decode valid, the execute bundle and the penalty count are registered and appear one edge later. The second bubble of R10 appears two edges after the branch. The bench drives every stimulus half a period before an edge and queues one expected record per cycle. That record carries the same-cycle combinational values together with the registered state that the previous edge must have produced. The monitor compares each record one time unit after the drive, so every check samples exactly one edge's worth of update. A second instance with a three-bit counter lets the saturation point be reached in a few branches.

// File: rtl/bfc_pkg.sv
// Package: shared constants and the hazard action type for the branch
// flush controller. Assumes IF is stage 1 and branches resolve in EX (stage 3).
package bfc_pkg;
    localparam int RESOLVE_STAGE = 3;
    localparam int FLUSH_SLOTS   = RESOLVE_STAGE - 1;

    typedef struct packed {
        logic redirect;
        logic flush_ifid;
        logic flush_idex;
        logic stall;
    } hazard_act_t;
endpackage

// File: rtl/bfc_decide.sv
// Module: bfc_decide
// Combinational hazard decision. Turns the resolved branch and the stall
// request into redirect, flush and effective-stall actions. Assumes the
// execute stage qualifies br_vld so that a bubble never presents a branch.
module bfc_decide
    import bfc_pkg::*;
(
    input  logic        br_vld,
    input  logic        br_cond,
    input  logic        stall_req,
    output hazard_act_t act
);
    logic taken;

    // Decide the actions: a taken branch flushes both younger slots and wins over a stall.
    always_comb begin
        taken          = br_vld & br_cond;
        act.redirect   = taken;
        act.flush_ifid = taken;
        act.flush_idex = taken;
        act.stall      = stall_req & ~taken;
    end
endmodule

// File: rtl/bfc_squash_regs.sv
// Module: bfc_squash_regs
// Holds the fetch/decode valid bit and the decode/execute control fields.
// It loads bubbles on flush, on stall (decode/execute only) and out of reset.
// Assumes the datapath parts of these pipeline registers live elsewhere and
// use the same flush and stall enables.
module bfc_squash_regs
    import bfc_pkg::*;
#(
    parameter int ALUOP_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  hazard_act_t        act,
    input  logic               fetch_vld,
    input  logic               id_vld,
    input  logic               id_reg_wr,
    input  logic               id_mem_wr,
    input  logic [ALUOP_W-1:0] id_alu_op,
    output logic               if_vld,
    output logic               ex_vld,
    output logic               ex_reg_wr,
    output logic               ex_mem_wr,
    output logic [ALUOP_W-1:0] ex_alu_op
);
    localparam int BUNDLE_W = ALUOP_W + 3;

    logic [BUNDLE_W-1:0] live_bundle;
    logic [BUNDLE_W-1:0] ex_q;
    logic                slot_live;

    // Build the sanitised bundle: a slot with no real instruction becomes all zeros.
    always_comb begin
        slot_live   = if_vld & id_vld;
        live_bundle = slot_live ? {1'b1, id_reg_wr, id_mem_wr, id_alu_op}
                                : '0;
    end

    // Fetch/decode valid: cleared by flush, held by stall, otherwise loaded from fetch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            if_vld <= 1'b0;
        end else if (act.flush_ifid) begin
            if_vld <= 1'b0;
        end else if (!act.stall) begin
            if_vld <= fetch_vld;
        end
    end

    // Decode/execute control: bubble on flush or stall, otherwise the sanitised bundle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ex_q <= '0;
        end else if (act.flush_idex || act.stall) begin
            ex_q <= '0;
        end else begin
            ex_q <= live_bundle;
        end
    end

    assign {ex_vld, ex_reg_wr, ex_mem_wr, ex_alu_op} = ex_q;
endmodule

// File: rtl/bfc_penalty_cnt.sv
// Module: bfc_penalty_cnt
// Saturating count of fetch slots lost to taken branches. Each redirect
// adds FLUSH_SLOTS. Assumes CNT_W is wide enough to hold FLUSH_SLOTS.
module bfc_penalty_cnt
    import bfc_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    output logic [CNT_W-1:0] cnt
);
    localparam logic [CNT_W-1:0] SAT_MAX  = '1;
    localparam logic [CNT_W-1:0] STEP     = CNT_W'(FLUSH_SLOTS);
    localparam logic [CNT_W-1:0] STEP_LIM = SAT_MAX - STEP;

    logic [CNT_W-1:0] cnt_nxt;

    // Next count: add the step, or pin at the ceiling when the step would overflow.
    always_comb begin
        cnt_nxt = cnt;
        if (inc) begin
            cnt_nxt = (cnt > STEP_LIM) ? SAT_MAX : cnt + STEP;
        end
    end

    // Count register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else begin
            cnt <= cnt_nxt;
        end
    end
endmodule

// File: rtl/branch_flush_ctrl.sv
// Module: branch_flush_ctrl
// Control-hazard controller for a five-stage, predict-fall-through pipeline.
// A taken branch resolved in execute redirects the PC, squashes the two
// younger slots into bubbles, overrides stalls and counts the lost slots.
// Assumes the execute stage presents the branch result and target combinationally.
module branch_flush_ctrl
    import bfc_pkg::*;
#(
    parameter int PC_W    = 32,
    parameter int ALUOP_W = 4,
    parameter int CNT_W   = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               fetch_vld,
    input  logic               id_vld,
    input  logic               id_reg_wr,
    input  logic               id_mem_wr,
    input  logic [ALUOP_W-1:0] id_alu_op,
    input  logic               stall_req,
    input  logic               ex_br_vld,
    input  logic               ex_br_taken,
    input  logic [PC_W-1:0]    ex_br_target,
    output logic               pc_sel,
    output logic [PC_W-1:0]    pc_target,
    output logic               flush_ifid,
    output logic               flush_idex,
    output logic               stall_out,
    output logic               if_vld,
    output logic               ex_vld,
    output logic               ex_reg_wr,
    output logic               ex_mem_wr,
    output logic [ALUOP_W-1:0] ex_alu_op,
    output logic [CNT_W-1:0]   penalty_cnt
);
    hazard_act_t act;

    bfc_decide u_decide (
        .br_vld    (ex_br_vld),
        .br_cond   (ex_br_taken),
        .stall_req (stall_req),
        .act       (act)
    );

    bfc_squash_regs #(.ALUOP_W(ALUOP_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .act       (act),
        .fetch_vld (fetch_vld),
        .id_vld    (id_vld),
        .id_reg_wr (id_reg_wr),
        .id_mem_wr (id_mem_wr),
        .id_alu_op (id_alu_op),
        .if_vld    (if_vld),
        .ex_vld    (ex_vld),
        .ex_reg_wr (ex_reg_wr),
        .ex_mem_wr (ex_mem_wr),
        .ex_alu_op (ex_alu_op)
    );

    bfc_penalty_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (act.redirect),
        .cnt   (penalty_cnt)
    );

    // Drive the PC steering and flush enables from the decided actions.
    always_comb begin
        pc_sel     = act.redirect;
        pc_target  = ex_br_target;
        flush_ifid = act.flush_ifid;
        flush_idex = act.flush_idex;
        stall_out  = act.stall;
    end
endmodule

// File: rtl/bfc_checker.sv
// Module: bfc_checker
// Property checks on the flush controller's ports, bound to every instance.
module bfc_checker
    import bfc_pkg::*;
#(
    parameter int PC_W    = 32,
    parameter int ALUOP_W = 4,
    parameter int CNT_W   = 32
) (
    input logic               clk,
    input logic               rst_n,
    input logic               stall_req,
    input logic               ex_br_vld,
    input logic               ex_br_taken,
    input logic               pc_sel,
    input logic               flush_ifid,
    input logic               flush_idex,
    input logic               stall_out,
    input logic               if_vld,
    input logic               ex_vld,
    input logic               ex_reg_wr,
    input logic               ex_mem_wr,
    input logic [ALUOP_W-1:0] ex_alu_op,
    input logic [CNT_W-1:0]   penalty_cnt
);
    localparam logic [CNT_W-1:0] SAT_MAX  = '1;
    localparam logic [CNT_W-1:0] STEP     = CNT_W'(FLUSH_SLOTS);
    localparam logic [CNT_W-1:0] STEP_LIM = SAT_MAX - STEP;

    logic br_hit;
    assign br_hit = ex_br_vld & ex_br_taken;

    p_redirect_r2: assert property (@(posedge clk) disable iff (!rst_n)
        br_hit |-> pc_sel);

    p_flush_pair_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_ifid == flush_idex) && (flush_ifid == pc_sel));

    p_bubble_after_flush_r4: assert property (@(posedge clk) disable iff (!rst_n)
        br_hit |=> (!if_vld && !ex_vld && !ex_reg_wr && !ex_mem_wr && ex_alu_op == '0));

    p_no_cost_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !br_hit |=> $stable(penalty_cnt));

    p_flush_beats_stall_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (br_hit && stall_req) |-> !stall_out);

    p_stall_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        stall_out |=> (if_vld == $past(if_vld)) && !ex_vld);

    p_cnt_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (br_hit && penalty_cnt <= STEP_LIM) |=> penalty_cnt == $past(penalty_cnt) + STEP);

    p_cnt_sat_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (br_hit && penalty_cnt > STEP_LIM) |=> penalty_cnt == SAT_MAX);

    p_second_bubble_r10: assert property (@(posedge clk) disable iff (!rst_n)
        br_hit |=> ##1 !ex_vld);
endmodule

bind branch_flush_ctrl bfc_checker #(
    .PC_W(PC_W), .ALUOP_W(ALUOP_W), .CNT_W(CNT_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .stall_req   (stall_req),
    .ex_br_vld   (ex_br_vld),
    .ex_br_taken (ex_br_taken),
    .pc_sel      (pc_sel),
    .flush_ifid  (flush_ifid),
    .flush_idex  (flush_idex),
    .stall_out   (stall_out),
    .if_vld      (if_vld),
    .ex_vld      (ex_vld),
    .ex_reg_wr   (ex_reg_wr),
    .ex_mem_wr   (ex_mem_wr),
    .ex_alu_op   (ex_alu_op),
    .penalty_cnt (penalty_cnt)
);

// File: tb/test_branch_flush_ctrl.sv
// Scoreboard bench: the driver queues one expected record per cycle and the
// monitor compares it one time unit after the inputs are driven.
module test_branch_flush_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int PC_W       = 32;
    localparam int ALUOP_W    = 4;
    localparam int CNT_W      = 32;
    localparam int NCNT_W     = 3;
    localparam int WATCHDOG   = 2000;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               fetch_vld = 1'b0, id_vld = 1'b0, id_reg_wr = 1'b0, id_mem_wr = 1'b0;
    logic [ALUOP_W-1:0] id_alu_op = '0;
    logic               stall_req = 1'b0, ex_br_vld = 1'b0, ex_br_taken = 1'b0;
    logic [PC_W-1:0]    ex_br_target = '0;

    logic               pc_sel, flush_ifid, flush_idex, stall_out, if_vld;
    logic               ex_vld, ex_reg_wr, ex_mem_wr;
    logic [ALUOP_W-1:0] ex_alu_op;
    logic [PC_W-1:0]    pc_target;
    logic [CNT_W-1:0]   penalty_cnt;

    logic               n_pc_sel, n_flush_ifid, n_flush_idex, n_stall_out, n_if_vld;
    logic               n_ex_vld, n_ex_reg_wr, n_ex_mem_wr;
    logic [ALUOP_W-1:0] n_ex_alu_op;
    logic [PC_W-1:0]    n_pc_target;
    logic [NCNT_W-1:0]  n_penalty_cnt;

    always #(CLK_PERIOD/2) clk = ~clk;

    branch_flush_ctrl #(.PC_W(PC_W), .ALUOP_W(ALUOP_W), .CNT_W(CNT_W)) i_branch_flush_ctrl (
        .clk(clk), .rst_n(rst_n), .fetch_vld(fetch_vld), .id_vld(id_vld),
        .id_reg_wr(id_reg_wr), .id_mem_wr(id_mem_wr), .id_alu_op(id_alu_op),
        .stall_req(stall_req), .ex_br_vld(ex_br_vld), .ex_br_taken(ex_br_taken),
        .ex_br_target(ex_br_target), .pc_sel(pc_sel), .pc_target(pc_target),
        .flush_ifid(flush_ifid), .flush_idex(flush_idex), .stall_out(stall_out),
        .if_vld(if_vld), .ex_vld(ex_vld), .ex_reg_wr(ex_reg_wr), .ex_mem_wr(ex_mem_wr),
        .ex_alu_op(ex_alu_op), .penalty_cnt(penalty_cnt)
    );

    branch_flush_ctrl #(.PC_W(PC_W), .ALUOP_W(ALUOP_W), .CNT_W(NCNT_W)) i_branch_flush_ctrl_narrow (
        .clk(clk), .rst_n(rst_n), .fetch_vld(fetch_vld), .id_vld(id_vld),
        .id_reg_wr(id_reg_wr), .id_mem_wr(id_mem_wr), .id_alu_op(id_alu_op),
        .stall_req(stall_req), .ex_br_vld(ex_br_vld), .ex_br_taken(ex_br_taken),
        .ex_br_target(ex_br_target), .pc_sel(n_pc_sel), .pc_target(n_pc_target),
        .flush_ifid(n_flush_ifid), .flush_idex(n_flush_idex), .stall_out(n_stall_out),
        .if_vld(n_if_vld), .ex_vld(n_ex_vld), .ex_reg_wr(n_ex_reg_wr), .ex_mem_wr(n_ex_mem_wr),
        .ex_alu_op(n_ex_alu_op), .penalty_cnt(n_penalty_cnt)
    );

    typedef struct {
        string              req;
        bit                 taken;
        bit                 stall_o;
        logic [PC_W-1:0]    tgt;
        bit                 ifv;
        bit                 exv, exrw, exmw;
        logic [ALUOP_W-1:0] exalu;
        logic [CNT_W-1:0]   cnt;
        logic [NCNT_W-1:0]  ncnt;
    } exp_t;

    exp_t q[$];
    int   checks = 0;
    int   failures = 0;
    bit   done = 1'b0;

    // Reference state: what the previous edge must have left in the registers.
    bit                 r_ifv = 0, r_exv = 0, r_exrw = 0, r_exmw = 0;
    logic [ALUOP_W-1:0] r_exalu = '0;
    logic [CNT_W-1:0]   r_cnt = '0;
    logic [NCNT_W-1:0]  r_ncnt = '0;

    task automatic check(string req, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
        end
    endtask

    // Driver: apply one cycle of inputs, queue the expected record, advance the reference state.
    task automatic step(bit r, bit fv, bit iv, bit rw, bit mw, logic [ALUOP_W-1:0] alu,
                        bit st, bit bv, bit bt, logic [PC_W-1:0] tgt, string req);
        exp_t e;
        bit   tk;
        bit   so;
        @(negedge clk);
        rst_n = r; fetch_vld = fv; id_vld = iv; id_reg_wr = rw; id_mem_wr = mw;
        id_alu_op = alu; stall_req = st; ex_br_vld = bv; ex_br_taken = bt; ex_br_target = tgt;
        tk = bv & bt;
        so = st & ~tk;
        e.req = req; e.taken = tk; e.stall_o = so; e.tgt = tgt;
        e.ifv = r_ifv; e.exv = r_exv; e.exrw = r_exrw; e.exmw = r_exmw; e.exalu = r_exalu;
        e.cnt = r_cnt; e.ncnt = r_ncnt;
        q.push_back(e);
        if (!r) begin
            r_ifv = 0; r_exv = 0; r_exrw = 0; r_exmw = 0; r_exalu = '0; r_cnt = '0; r_ncnt = '0;
        end else if (tk) begin
            r_ifv = 0; r_exv = 0; r_exrw = 0; r_exmw = 0; r_exalu = '0;
            r_cnt = (r_cnt > {CNT_W{1'b1}} - 2) ? {CNT_W{1'b1}} : r_cnt + 2;
            r_ncnt = (r_ncnt > 3'd5) ? 3'd7 : r_ncnt + 3'd2;
        end else if (so) begin
            r_exv = 0; r_exrw = 0; r_exmw = 0; r_exalu = '0;
        end else begin
            if (r_ifv && iv) begin
                r_exv = 1; r_exrw = rw; r_exmw = mw; r_exalu = alu;
            end else begin
                r_exv = 0; r_exrw = 0; r_exmw = 0; r_exalu = '0;
            end
            r_ifv = fv;
        end
    endtask

    // Monitor: pop each queued record and compare against both instances.
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                check({e.req, "/R2"}, "pc_sel", 64'(pc_sel), 64'(e.taken));
                if (e.taken) check({e.req, "/R2"}, "pc_target", 64'(pc_target), 64'(e.tgt));
                check({e.req, "/R3"}, "flush_ifid", 64'(flush_ifid), 64'(e.taken));
                check({e.req, "/R3"}, "flush_idex", 64'(flush_idex), 64'(e.taken));
                check({e.req, "/R6"}, "stall_out", 64'(stall_out), 64'(e.stall_o));
                check(e.req, "if_vld", 64'(if_vld), 64'(e.ifv));
                check(e.req, "ex_bundle", 64'({ex_vld, ex_reg_wr, ex_mem_wr, ex_alu_op}),
                      64'({e.exv, e.exrw, e.exmw, e.exalu}));
                check({e.req, "/R9"}, "penalty_cnt", 64'(penalty_cnt), 64'(e.cnt));
                check({e.req, "/R9"}, "narrow_cnt", 64'(n_penalty_cnt), 64'(e.ncnt));
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    // Stimulus sequence.
    initial begin
        // R1: reset state
        step(0, 0,0,0,0,4'h0, 0,0,0, 32'h0, "R1");
        step(0, 0,0,0,0,4'h0, 0,0,0, 32'h0, "R1");
        step(1, 1,0,0,0,4'h0, 0,0,0, 32'h0, "R1");
        // R8: normal flow with varied decoded bundles
        step(1, 1,1,1,0,4'h5, 0,0,0, 32'h0, "R8");
        step(1, 1,1,0,1,4'hA, 0,0,0, 32'h0, "R8");
        step(1, 1,0,1,1,4'hF, 0,0,0, 32'h0, "R8");
        step(1, 1,1,1,1,4'h3, 0,0,0, 32'h0, "R8");
        // R5: not taken, and condition set without a valid branch
        step(1, 1,1,1,0,4'h6, 0,1,0, 32'h40, "R5");
        step(1, 1,1,0,1,4'h2, 0,0,1, 32'h80, "R5");
        step(1, 1,1,1,0,4'h1, 0,0,0, 32'h0, "R5");
        // R2/R4/R10: taken branch then two bubble slots
        step(1, 1,1,1,0,4'h7, 0,1,1, 32'h100, "R4");
        step(1, 1,1,1,1,4'h9, 0,0,0, 32'h0, "R4");
        step(1, 1,1,1,1,4'hB, 0,0,0, 32'h0, "R10");
        step(1, 1,1,0,1,4'hC, 0,0,0, 32'h0, "R10");
        step(1, 1,1,1,0,4'hD, 0,0,0, 32'h0, "R10");
        // R7: stall holds fetch/decode and bubbles execute
        step(1, 0,1,1,1,4'hE, 1,0,0, 32'h0, "R7");
        step(1, 0,1,1,1,4'hE, 1,0,0, 32'h0, "R7");
        step(1, 1,1,1,0,4'h4, 0,0,0, 32'h0, "R7");
        step(1, 1,1,0,0,4'h8, 0,0,0, 32'h0, "R7");
        // R6: stall and taken branch together
        step(1, 1,1,1,1,4'h5, 1,1,1, 32'h200, "R6");
        step(1, 1,1,1,0,4'h6, 0,0,0, 32'h0, "R6");
        step(1, 1,1,1,0,4'h6, 0,0,0, 32'h0, "R6");
        // R9: back-to-back taken branches drive the narrow counter into saturation
        step(1, 1,1,1,0,4'h1, 0,1,1, 32'h300, "R9");
        step(1, 1,1,1,0,4'h1, 0,1,1, 32'h304, "R9");
        step(1, 1,1,1,0,4'h1, 0,1,1, 32'h308, "R9");
        step(1, 1,1,1,0,4'h1, 0,1,1, 32'h30C, "R9");
        step(1, 1,1,1,0,4'h1, 0,0,0, 32'h0, "R9");
        step(1, 1,1,1,0,4'h1, 0,0,0, 32'h0, "R9");
        // R1: reset in mid-run clears everything
        step(0, 1,1,1,1,4'hF, 0,0,0, 32'h0, "R1");
        step(1, 0,0,0,0,4'h0, 0,0,0, 32'h0, "R1");
        step(1, 0,0,0,0,4'h0, 0,0,0, 32'h0, "R1");
        @(negedge clk);
        #2;
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule